// File: doc/BRIEF.md
# Write Permission Guard with Region Locking

This block decides, for every write that a serial front end wants to perform, whether the write may go ahead. It keeps two volatile enable latches (a general write enable and a second enable that is needed to alter the guard's own lock field). It also keeps a two-bit lock field that models a nonvolatile setting. The lock field fences off the upper part of a byte-addressed memory array and, at its strongest setting, both potentiometer wipers. A hardware write-protect pin overrides the latches for every nonvolatile write.

The front end presents one request per cycle. A request carries a target (potentiometer A, potentiometer B, memory array or the guard's own register), an address, a volatile or nonvolatile flag and a data byte. The guard answers one cycle later with a permit or deny flag, which the front end uses to acknowledge or withhold acknowledge for the byte. A new lock value is only staged by the register write. The bus STOP strobe then starts a timed nonvolatile cycle, and the value is committed at the end of it. During that cycle every request is refused.

Top module: `write_guard`

## Requirements
- R1: After reset the write enable, the register enable, the lock field (value 00) and the busy flag are all 0, and no response is flagged.
- R2: A request to a potentiometer (target code 0 or 1) or to the array (target code 2) is denied whenever the write enable latch is 0.
- R3: A register write (target code 3) while the register enable is 0 is permitted. Data bit 1 is loaded into the write enable. Data bit 2 sets the register enable only if the write enable was already 1. Data bits 4:3 leave the lock field unchanged.
- R4: A register write while the register enable is 1 and the pin is low is permitted and stages data bits 4:3. The lock output keeps its old value until a STOP strobe starts a busy period of NV_CYCLES cycles. At the end of that period the staged value appears on the lock output and both enable latches read 0.
- R5: With the write-protect pin high, array writes, nonvolatile potentiometer writes and lock-staging register writes are denied. A volatile potentiometer write with the write enable set is still permitted when the lock field is not 11.
- R6: The lock field is decoded as follows: 00 protects nothing; 01 protects array addresses whose two top bits are 11 (0xC0-0xFF); 10 protects addresses with the top bit set (0x80-0xFF); 11 protects the whole array and every potentiometer write. Denied writes leave all state unchanged.
- R7: While busy, every request is denied and the latches do not change.
- R8: Every request receives exactly one response, flagged in the cycle after it. No response is flagged in any cycle that does not follow a request.
- R9: A STOP strobe with nothing staged has no effect. A STOP strobe while the pin is high discards the staged value, leaves the lock field and the latches as they were, and starts no busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wpPin | input | 1 | Hardware write-protect, high blocks nonvolatile writes |
| reqValid | input | 1 | Write request present this cycle |
| reqTarget | input | 2 | 0 pot A, 1 pot B, 2 array, 3 guard register |
| reqAddr | input | ADDR_W | Array byte address |
| reqNonVol | input | 1 | Potentiometer write is nonvolatile |
| reqData | input | 8 | Data byte, used for register writes |
| stopStrobe | input | 1 | Bus STOP seen |
| respValid | output | 1 | Decision for last cycle's request |
| respPermit | output | 1 | 1 permit, 0 deny |
| welOut | output | 1 | Write enable latch |
| rwelOut | output | 1 | Register enable latch |
| lockOut | output | 2 | Committed lock field |
| nvBusy | output | 1 | Nonvolatile cycle in progress |

## Verification
On every cycle, the assertions check the one-cycle response timing, refusal when the write enable is clear, refusal while busy, refusal of array writes under the pin, denial of potentiometer writes at the full lock, the rule that the register enable only rises with the write enable already set, the stability of the lock field outside the commit point, and the clearing of both latches when the busy period ends. Only the bench scenarios can show the region boundaries at each lock setting (0xBF against 0xC0, 0x7F against 0x80), the exact length of the busy period and the late appearance of the staged lock value. They also cover the discarding of a staged value by a STOP under the pin and a STOP with nothing staged.

// File: rtl/write_guard_pkg.sv
package write_guard_pkg;

  typedef enum logic [1:0] {
    TGT_POT_A = 2'd0,
    TGT_POT_B = 2'd1,
    TGT_ARRAY = 2'd2,
    TGT_CTRL  = 2'd3
  } target_e;

  localparam int WEL_BIT  = 1;
  localparam int RWEL_BIT = 2;
  localparam int LOCK_LSB = 3;
  localparam int LOCK_MSB = 4;

  typedef struct packed {
    logic       welLoad;
    logic       welVal;
    logic       rwelSet;
    logic       pendLoad;
    logic [1:0] pendVal;
    logic       disarm;
    logic       nvStart;
  } ctrl_strobe_t;

  // topBits are the two most significant address bits
  function automatic logic regionLocked(input logic [1:0] lock, input logic [1:0] topBits);
    unique case (lock)
      2'b00:   return 1'b0;
      2'b01:   return topBits == 2'b11;
      2'b10:   return topBits[1];
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/write_guard_decide.sv
module write_guard_decide
  import write_guard_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wpPin,
  input  logic         reqValid,
  input  target_e      reqTarget,
  input  logic [1:0]   reqTop,
  input  logic         reqNonVol,
  input  logic [7:0]   reqData,
  input  logic         stopStrobe,
  input  logic         wel,
  input  logic         rwel,
  input  logic         armed,
  input  logic         busy,
  input  logic [1:0]   lock,
  output ctrl_strobe_t strobe,
  output logic         respValid,
  output logic         respPermit
);

  logic permitNext;

  always_comb begin
    strobe     = '0;
    permitNext = 1'b0;
    if (reqValid && !busy) begin
      unique case (reqTarget)
        TGT_POT_A, TGT_POT_B:
          permitNext = wel && (lock != 2'b11) && !(reqNonVol && wpPin);
        TGT_ARRAY:
          permitNext = wel && !wpPin && !regionLocked(lock, reqTop);
        default: begin
          if (rwel) begin
            if (!wpPin) begin
              permitNext      = 1'b1;
              strobe.pendLoad = 1'b1;
              strobe.pendVal  = reqData[LOCK_MSB:LOCK_LSB];
            end
          end else begin
            permitNext     = 1'b1;
            strobe.welLoad = 1'b1;
            strobe.welVal  = reqData[WEL_BIT];
            strobe.rwelSet = reqData[RWEL_BIT] && wel;
          end
        end
      endcase
    end
    if (stopStrobe && armed && !busy) begin
      strobe.disarm  = 1'b1;
      strobe.nvStart = !wpPin;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid  <= 1'b0;
      respPermit <= 1'b0;
    end else begin
      respValid  <= reqValid;
      respPermit <= permitNext;
    end
  end

  p_resp_follows_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);
  p_no_spurious_resp_r8: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid);
  p_deny_without_wel_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqTarget != TGT_CTRL && !wel) |=> !respPermit);
  p_deny_while_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && busy) |=> !respPermit);
  p_pin_blocks_array_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && wpPin && reqTarget == TGT_ARRAY) |=> !respPermit);
  p_full_lock_pots_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && lock == 2'b11 && (reqTarget == TGT_POT_A || reqTarget == TGT_POT_B)) |=> !respPermit);

endmodule

// File: rtl/write_guard_state.sv
module write_guard_state
  import write_guard_pkg::*;
#(
  parameter int NV_CYCLES = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_strobe_t strobe,
  output logic         wel,
  output logic         rwel,
  output logic         armed,
  output logic         busy,
  output logic [1:0]   lock
);

  localparam int CNT_W = (NV_CYCLES > 2) ? $clog2(NV_CYCLES) : 1;

  logic [1:0]       pend;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wel   <= 1'b0;
      rwel  <= 1'b0;
      armed <= 1'b0;
      busy  <= 1'b0;
      lock  <= 2'b00;
      pend  <= 2'b00;
      cnt   <= '0;
    end else if (busy) begin
      if (cnt == '0) begin
        busy <= 1'b0;
        lock <= pend;
        wel  <= 1'b0;
        rwel <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else begin
      if (strobe.welLoad) wel  <= strobe.welVal;
      if (strobe.rwelSet) rwel <= 1'b1;
      if (strobe.pendLoad) begin
        pend  <= strobe.pendVal;
        armed <= 1'b1;
      end
      if (strobe.disarm) armed <= 1'b0;
      if (strobe.nvStart) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(NV_CYCLES - 1);
      end
    end
  end

  p_lock_holds_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busy || cnt != '0) |=> $stable(lock));
  p_latches_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (!wel && !rwel));
  p_rwel_needs_wel_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rwel) |-> $past(wel));
  p_busy_freezes_wel_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt != '0) |=> $stable(wel) && $stable(rwel));

endmodule

// File: rtl/write_guard.sv
module write_guard
  import write_guard_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NV_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wpPin,
  input  logic              reqValid,
  input  logic [1:0]        reqTarget,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqNonVol,
  input  logic [7:0]        reqData,
  input  logic              stopStrobe,
  output logic              respValid,
  output logic              respPermit,
  output logic              welOut,
  output logic              rwelOut,
  output logic [1:0]        lockOut,
  output logic              nvBusy
);

  ctrl_strobe_t strobe;
  logic         armed;

  write_guard_decide u_decide (
    .clk        (clk),
    .rstN       (rstN),
    .wpPin      (wpPin),
    .reqValid   (reqValid),
    .reqTarget  (target_e'(reqTarget)),
    .reqTop     (reqAddr[ADDR_W-1:ADDR_W-2]),
    .reqNonVol  (reqNonVol),
    .reqData    (reqData),
    .stopStrobe (stopStrobe),
    .wel        (welOut),
    .rwel       (rwelOut),
    .armed      (armed),
    .busy       (nvBusy),
    .lock       (lockOut),
    .strobe     (strobe),
    .respValid  (respValid),
    .respPermit (respPermit)
  );

  write_guard_state #(.NV_CYCLES(NV_CYCLES)) u_state (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wel    (welOut),
    .rwel   (rwelOut),
    .armed  (armed),
    .busy   (nvBusy),
    .lock   (lockOut)
  );

endmodule

// File: tb/tb_write_guard.sv
module tb_write_guard;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wpPin = 1'b0;
  logic       reqValid = 1'b0;
  logic [1:0] reqTarget = 2'd0;
  logic [7:0] reqAddr = 8'd0;
  logic       reqNonVol = 1'b0;
  logic [7:0] reqData = 8'd0;
  logic       stopStrobe = 1'b0;
  logic       respValid, respPermit, welOut, rwelOut, nvBusy;
  logic [1:0] lockOut;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  write_guard #(.ADDR_W(8), .NV_CYCLES(NV)) dut (
    .clk(clk), .rstN(rstN), .wpPin(wpPin), .reqValid(reqValid),
    .reqTarget(reqTarget), .reqAddr(reqAddr), .reqNonVol(reqNonVol),
    .reqData(reqData), .stopStrobe(stopStrobe), .respValid(respValid),
    .respPermit(respPermit), .welOut(welOut), .rwelOut(rwelOut),
    .lockOut(lockOut), .nvBusy(nvBusy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one request; response is sampled at the negedge after the sampling posedge
  task automatic req(input logic [1:0] t, input logic [7:0] a, input logic nv,
                     input logic [7:0] d, input logic expPermit, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqTarget = t; reqAddr = a; reqNonVol = nv; reqData = d;
    @(negedge clk);
    reqValid = 1'b0;
    chk(respValid == 1'b1, "R8 response flagged", int'(respValid), 1);
    chk(respPermit == expPermit, tag, int'(respPermit), int'(expPermit));
  endtask

  task automatic stopPulse();
    @(negedge clk);
    stopStrobe = 1'b1;
    @(negedge clk);
    stopStrobe = 1'b0;
  endtask

  task automatic setLock(input logic [1:0] v);
    req(2'd3, 8'h00, 1'b0, 8'h02, 1'b1, "R3 set wel");
    req(2'd3, 8'h00, 1'b0, 8'h06, 1'b1, "R3 set rwel");
    req(2'd3, 8'h00, 1'b0, {3'b000, v, 3'b000}, 1'b1, "R4 stage lock");
    stopPulse();
    repeat (NV + 2) @(negedge clk);
    chk(lockOut == v, "R4 lock committed", int'(lockOut), int'(v));
  endtask

  task automatic t_reset();
    chk(welOut == 1'b0, "R1 wel reset", int'(welOut), 0);
    chk(rwelOut == 1'b0, "R1 rwel reset", int'(rwelOut), 0);
    chk(lockOut == 2'b00, "R1 lock reset", int'(lockOut), 0);
    chk(nvBusy == 1'b0, "R1 busy reset", int'(nvBusy), 0);
    chk(respValid == 1'b0, "R1 no response", int'(respValid), 0);
  endtask

  task automatic t_no_wel();
    req(2'd2, 8'h10, 1'b0, 8'h00, 1'b0, "R2 array without wel");
    req(2'd0, 8'h00, 1'b1, 8'h00, 1'b0, "R2 pot A without wel");
    req(2'd1, 8'h00, 1'b0, 8'h00, 1'b0, "R2 pot B volatile without wel");
    @(negedge clk);
    chk(respValid == 1'b0, "R8 idle no response", int'(respValid), 0);
  endtask

  task automatic t_reg_volatile();
    req(2'd3, 8'h00, 1'b0, 8'h04, 1'b1, "R3 rwel-only write permitted");
    chk(rwelOut == 1'b0, "R3 rwel needs wel", int'(rwelOut), 0);
    req(2'd3, 8'h00, 1'b0, 8'h02, 1'b1, "R3 wel write");
    chk(welOut == 1'b1, "R3 wel loaded", int'(welOut), 1);
    req(2'd3, 8'h00, 1'b0, 8'h1E, 1'b1, "R3 rwel with lock bits");
    chk(rwelOut == 1'b1, "R3 rwel set", int'(rwelOut), 1);
    chk(lockOut == 2'b00, "R3 lock untouched", int'(lockOut), 0);
    req(2'd0, 8'h00, 1'b1, 8'h00, 1'b1, "R2 pot write with wel");
  endtask

  task automatic t_lock_commit();
    int n;
    req(2'd3, 8'h00, 1'b0, 8'h08, 1'b1, "R4 stage 01");
    chk(lockOut == 2'b00, "R4 lock before stop", int'(lockOut), 0);
    stopPulse();
    n = 0;
    if (nvBusy) n++;
    reqValid = 1'b1; reqTarget = 2'd2; reqAddr = 8'h00; reqNonVol = 1'b0; reqData = 8'h00;
    @(negedge clk);
    reqValid = 1'b0;
    chk(respValid && !respPermit, "R7 deny while busy", int'(respPermit), 0);
    chk(welOut == 1'b1, "R7 wel held while busy", int'(welOut), 1);
    if (nvBusy) n++;
    for (int i = 0; i < NV + 4; i++) begin
      @(negedge clk);
      if (nvBusy) n++;
    end
    chk(n == NV, "R4 busy length", n, NV);
    chk(lockOut == 2'b01, "R4 lock after cycle", int'(lockOut), 1);
    chk(welOut == 1'b0, "R4 wel cleared", int'(welOut), 0);
    chk(rwelOut == 1'b0, "R4 rwel cleared", int'(rwelOut), 0);
  endtask

  task automatic t_regions();
    req(2'd3, 8'h00, 1'b0, 8'h02, 1'b1, "R3 set wel");
    req(2'd2, 8'hBF, 1'b0, 8'h00, 1'b1, "R6 lock01 0xBF open");
    req(2'd2, 8'hC0, 1'b0, 8'h00, 1'b0, "R6 lock01 0xC0 locked");
    req(2'd0, 8'h00, 1'b1, 8'h00, 1'b1, "R6 lock01 pot open");
    setLock(2'b10);
    req(2'd3, 8'h00, 1'b0, 8'h02, 1'b1, "R3 set wel");
    req(2'd2, 8'h7F, 1'b0, 8'h00, 1'b1, "R6 lock10 0x7F open");
    req(2'd2, 8'h80, 1'b0, 8'h00, 1'b0, "R6 lock10 0x80 locked");
    setLock(2'b11);
    req(2'd3, 8'h00, 1'b0, 8'h02, 1'b1, "R3 set wel");
    req(2'd2, 8'h00, 1'b0, 8'h00, 1'b0, "R6 lock11 0x00 locked");
    req(2'd1, 8'h00, 1'b0, 8'h00, 1'b0, "R6 lock11 pot volatile locked");
    chk(lockOut == 2'b11, "R6 denied write keeps lock", int'(lockOut), 3);
    setLock(2'b00);
    req(2'd3, 8'h00, 1'b0, 8'h02, 1'b1, "R3 set wel");
    req(2'd2, 8'hFF, 1'b0, 8'h00, 1'b1, "R6 lock00 0xFF open");
  endtask

  task automatic t_pin();
    wpPin = 1'b1;
    req(2'd2, 8'h00, 1'b0, 8'h00, 1'b0, "R5 pin blocks array");
    req(2'd0, 8'h00, 1'b1, 8'h00, 1'b0, "R5 pin blocks nonvolatile pot");
    req(2'd1, 8'h00, 1'b0, 8'h00, 1'b1, "R5 volatile pot under pin");
    req(2'd3, 8'h00, 1'b0, 8'h06, 1'b1, "R3 set rwel under pin");
    req(2'd3, 8'h00, 1'b0, 8'h18, 1'b0, "R5 pin blocks lock staging");
    stopPulse();
    @(negedge clk);
    chk(nvBusy == 1'b0, "R5 no cycle after blocked stage", int'(nvBusy), 0);
    chk(lockOut == 2'b00, "R5 lock unchanged", int'(lockOut), 0);
    wpPin = 1'b0;
  endtask

  task automatic t_stop_cases();
    stopPulse();
    @(negedge clk);
    chk(nvBusy == 1'b0, "R9 bare stop no busy", int'(nvBusy), 0);
    chk(rwelOut == 1'b1, "R9 bare stop keeps rwel", int'(rwelOut), 1);
    req(2'd3, 8'h00, 1'b0, 8'h08, 1'b1, "R4 stage 01");
    wpPin = 1'b1;
    stopPulse();
    @(negedge clk);
    chk(nvBusy == 1'b0, "R9 stop under pin no busy", int'(nvBusy), 0);
    chk(lockOut == 2'b00, "R9 stop under pin lock kept", int'(lockOut), 0);
    wpPin = 1'b0;
    stopPulse();
    @(negedge clk);
    chk(nvBusy == 1'b0, "R9 staged value discarded", int'(nvBusy), 0);
    chk(welOut == 1'b1 && rwelOut == 1'b1, "R9 latches kept", int'({welOut, rwelOut}), 3);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_wel();
    t_reg_volatile();
    t_lock_commit();
    t_regions();
    t_pin();
    t_stop_cases();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule